// File: doc/BRIEF.md
# Windowed Speckle Contrast Engine

This block turns a 5×5 patch of 8-bit image samples into one speckle contrast value. Speckle contrast is the ratio of the standard deviation to the mean over the patch, also called the coefficient of variation. The caller pulses `start` and streams the samples with `pixValid`. The engine builds the running sum S1 and the sum of squares S2 over 30 cycles. It then forms the radicand 25·S2 − S1² and takes its integer square root, one result bit per cycle, most significant bit first. Finally it divides that root by S1 with a shift-and-subtract loop, also most significant bit first.

The work splits into two slots of 30 cycles each, which are sequenced by cycle counters. The first slot collects samples and the second does the arithmetic. Because the two slots overlap, a new window can start every 30 cycles. Each result appears 60 cycles after its start as an unsigned fixed-point number with 13 integer bits and 15 fraction bits, marked by a one-cycle `done` pulse.

Top module: `speckle_contrast_engine`

## Requirements
- R1: While reset is held and right after it, `done` is low and `kOut` is zero.
- R2: A `start` is accepted only when no collection slot is open. An accepted start opens a 30-cycle slot. A `start` seen in any cycle of an open slot, its last cycle included, is ignored. A `start` in the cycle right after the slot closes is accepted.
- R3: Within a slot, the first cycle included, every cycle with `pixValid` high contributes `pixIn`, up to the first 25 such samples. Later valid samples in the slot are ignored, and samples that never arrive count as zero.
- R4: If `start` is accepted at clock edge n, `done` is high for exactly the one cycle that follows edge n+59, so the start cycle is cycle 1 and `done` is in cycle 60. `done` is low at every other time.
- R5: At `done`, `kOut` equals floor(floor(sqrt(25·S2 − S1²))·2^15 / S1), 28 bits wide. Bits 27..15 are the integer part and bits 14..0 are the fraction.
- R6: When S1 is zero, `kOut` is 0 and `done` still pulses on schedule.
- R7: A window in which all samples are equal (25 valid samples) gives `kOut` = 0.
- R8: `kOut` keeps its value in every cycle without `done`.
- R9: Starts issued every 30 cycles give one correct result every 30 cycles.
- R10: `kOut` stays below 5.0, that is below 5·2^15, since the ratio cannot exceed sqrt(24).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a collection slot when none is open |
| pixValid | input | 1 | `pixIn` carries a sample this cycle |
| pixIn | input | 8 | Unsigned sample value |
| done | output | 1 | One-cycle result strobe |
| kOut | output | 28 | Contrast, unsigned Q13.15 |

## Verification
The assertions check the timing contract on every cycle: `done` matches an accepted start from 59 edges earlier, no two accepted starts lie closer than a slot apart, `kOut` is frozen outside `done`, and every result stays under the sqrt(24) bound. The arithmetic value itself, meaning the exact root and quotient bits, the zero-mean override, the capping at 25 samples and the treatment of gaps, can only be shown by the bench scenarios. There, an integer model recomputes each window from the samples it actually saw.

// File: rtl/sce_pkg.sv
package sce_pkg;

  // Strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic accFirst;   // accepted start: restart sums
    logic accTake;    // current sample is added
    logic launch;     // slot closes: hand sums to arithmetic
    logic radLoad;    // form radicand, seed root
    logic sqrtStep;   // one root bit
    logic divFirst;   // first quotient step uses fresh operands
    logic divStep;    // quotient steps this cycle
    logic finish;     // publish result
  } sce_strobe_t;

  function automatic int sumWidth(int pw, int n);
    int pmax = (1 << pw) - 1;
    return $clog2(n * pmax + 1);
  endfunction

  function automatic int sqWidth(int pw, int n);
    int pmax = (1 << pw) - 1;
    return $clog2(n * pmax * pmax + 1);
  endfunction

  function automatic int radWidth(int pw, int n);
    int pmax = (1 << pw) - 1;
    int w = $clog2(n * n * pmax * pmax + 1);
    return w + (w % 2);
  endfunction

  function automatic int quotWidth(int pw, int n, int fw);
    return radWidth(pw, n) / 2 + fw;
  endfunction

endpackage

// File: rtl/sce_control.sv
module sce_control
  import sce_pkg::*;
#(
  parameter int WIN_N     = 25,
  parameter int SLOT      = 30,
  parameter int ROOT_W    = 13,
  parameter int DIV_STEPS = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        pixValid,
  output sce_strobe_t strb
);
  localparam int CNT_W  = $clog2(SLOT + 1);
  localparam int TAKE_W = $clog2(WIN_N + 1);
  localparam logic [CNT_W-1:0] C_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(SLOT - 1);
  localparam logic [CNT_W-1:0] C_SQLO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_SQHI  = CNT_W'(1 + ROOT_W);
  localparam logic [CNT_W-1:0] C_DVLO  = CNT_W'(2 + ROOT_W);
  localparam logic [CNT_W-1:0] C_DVHI  = CNT_W'(1 + ROOT_W + DIV_STEPS);
  localparam logic [CNT_W-1:0] C_FIN   = CNT_W'(SLOT);
  localparam logic [TAKE_W-1:0] T_MAX  = TAKE_W'(WIN_N);

  logic [CNT_W-1:0]  accCnt;
  logic [CNT_W-1:0]  calcCnt;
  logic [TAKE_W-1:0] taken;

  always_comb begin
    strb.accFirst = start && (accCnt == '0);
    strb.accTake  = pixValid && (strb.accFirst || ((accCnt != '0) && (taken < T_MAX)));
    strb.launch   = (accCnt == C_LAST);
    strb.radLoad  = (calcCnt == C_ONE);
    strb.sqrtStep = (calcCnt >= C_SQLO) && (calcCnt <= C_SQHI);
    strb.divFirst = (calcCnt == C_DVLO);
    strb.divStep  = (calcCnt >= C_DVLO) && (calcCnt <= C_DVHI);
    strb.finish   = (calcCnt == C_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accCnt  <= '0;
      calcCnt <= '0;
      taken   <= '0;
    end else begin
      if (strb.accFirst)      accCnt <= C_ONE;
      else if (strb.launch)   accCnt <= '0;
      else if (accCnt != '0)  accCnt <= accCnt + C_ONE;

      if (strb.accFirst)      taken <= pixValid ? TAKE_W'(1) : '0;
      else if (strb.accTake)  taken <= taken + TAKE_W'(1);

      if (strb.launch)        calcCnt <= C_ONE;
      else if (strb.finish)   calcCnt <= '0;
      else if (calcCnt != '0) calcCnt <= calcCnt + C_ONE;
    end
  end

endmodule

// File: rtl/sce_sqrt.sv
module sce_sqrt #(
  parameter int RAD_W  = 26,
  parameter int ROOT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [RAD_W-1:0]  radIn,
  output logic [ROOT_W-1:0] root
);
  localparam int REM_W = ROOT_W + 6;
  localparam int PAD_W = REM_W - ROOT_W - 2;

  logic [RAD_W-1:0]        radSh;
  logic signed [REM_W-1:0] rem;
  logic signed [REM_W-1:0] remShift;
  logic signed [REM_W-1:0] trialSub;
  logic signed [REM_W-1:0] trialAdd;
  logic signed [REM_W-1:0] remNext;

  // Non-restoring: the sign of the partial remainder picks add or subtract
  always_comb begin
    remShift = {rem[REM_W-3:0], radSh[RAD_W-1:RAD_W-2]};
    trialSub = {{PAD_W{1'b0}}, root, 2'b01};
    trialAdd = {{PAD_W{1'b0}}, root, 2'b11};
    remNext  = rem[REM_W-1] ? (remShift + trialAdd) : (remShift - trialSub);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      radSh <= '0;
      rem   <= '0;
      root  <= '0;
    end else if (load) begin
      radSh <= radIn;
      rem   <= '0;
      root  <= '0;
    end else if (step) begin
      radSh <= {radSh[RAD_W-3:0], 2'b00};
      rem   <= remNext;
      root  <= {root[ROOT_W-2:0], ~remNext[REM_W-1]};
    end
  end

endmodule

// File: rtl/sce_divider.sv
module sce_divider #(
  parameter int ROOT_W  = 13,
  parameter int FRAC_W  = 15,
  parameter int DIV_W   = 13,
  parameter int PER_CYC = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       first,
  input  logic                       step,
  input  logic [ROOT_W-1:0]          rootIn,
  input  logic [DIV_W-1:0]           divisor,
  output logic [ROOT_W+FRAC_W-1:0]   quot
);
  localparam int Q_W = ROOT_W + FRAC_W;

  logic [Q_W-1:0] dvd;
  logic [DIV_W:0] rem;
  logic [Q_W-1:0] dW;
  logic [Q_W-1:0] qW;
  logic [DIV_W:0] rW;
  logic [DIV_W:0] tW;

  // PER_CYC shift-and-subtract steps chained in one cycle
  always_comb begin
    dW = first ? {rootIn, {FRAC_W{1'b0}}} : dvd;
    rW = first ? '0 : rem;
    qW = first ? '0 : quot;
    tW = '0;
    for (int i = 0; i < PER_CYC; i++) begin
      tW = {rW[DIV_W-1:0], dW[Q_W-1]};
      if (tW >= {1'b0, divisor}) begin
        rW = tW - {1'b0, divisor};
        qW = {qW[Q_W-2:0], 1'b1};
      end else begin
        rW = tW;
        qW = {qW[Q_W-2:0], 1'b0};
      end
      dW = {dW[Q_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd  <= '0;
      rem  <= '0;
      quot <= '0;
    end else if (step) begin
      dvd  <= dW;
      rem  <= rW;
      quot <= qW;
    end
  end

endmodule

// File: rtl/sce_datapath.sv
module sce_datapath
  import sce_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int WIN_N  = 25,
  parameter int FRAC_W = 15,
  parameter int S1_W   = 13,
  parameter int S2_W   = 21,
  parameter int RAD_W  = 26,
  parameter int ROOT_W = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  sce_strobe_t              strb,
  input  logic [PIX_W-1:0]         pixIn,
  output logic                     done,
  output logic [ROOT_W+FRAC_W-1:0] kOut
);
  localparam int Q_W  = ROOT_W + FRAC_W;
  localparam int SQ_W = 2 * PIX_W;

  logic [SQ_W-1:0]  pixSq;
  logic [S1_W-1:0]  s1Acc, s1Next, s1Hold;
  logic [S2_W-1:0]  s2Acc, s2Next, s2Hold;
  logic [RAD_W-1:0] scaled, s1Sq, radicand;
  logic [ROOT_W-1:0] root;
  logic [Q_W-1:0]   quot;

  always_comb begin
    pixSq    = SQ_W'(pixIn) * SQ_W'(pixIn);
    s1Next   = (strb.accFirst ? '0 : s1Acc) + (strb.accTake ? S1_W'(pixIn) : '0);
    s2Next   = (strb.accFirst ? '0 : s2Acc) + (strb.accTake ? S2_W'(pixSq) : '0);
    scaled   = RAD_W'(s2Hold) * RAD_W'(WIN_N);
    s1Sq     = RAD_W'(s1Hold) * RAD_W'(s1Hold);
    radicand = scaled - s1Sq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Acc  <= '0;
      s2Acc  <= '0;
      s1Hold <= '0;
      s2Hold <= '0;
    end else begin
      if (strb.accFirst || strb.accTake) begin
        s1Acc <= s1Next;
        s2Acc <= s2Next;
      end
      if (strb.launch) begin
        s1Hold <= s1Next;
        s2Hold <= s2Next;
      end
    end
  end

  sce_sqrt #(.RAD_W(RAD_W), .ROOT_W(ROOT_W)) u_sqrt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (strb.radLoad),
    .step  (strb.sqrtStep),
    .radIn (radicand),
    .root  (root)
  );

  sce_divider #(.ROOT_W(ROOT_W), .FRAC_W(FRAC_W), .DIV_W(S1_W), .PER_CYC(2)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .first   (strb.divFirst),
    .step    (strb.divStep),
    .rootIn  (root),
    .divisor (s1Hold),
    .quot    (quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      kOut <= '0;
    end else begin
      done <= strb.finish;
      if (strb.finish) kOut <= (s1Hold == '0) ? '0 : quot;
    end
  end

endmodule

// File: rtl/speckle_contrast_engine.sv
module speckle_contrast_engine
  import sce_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int WIN_N  = 25,
  parameter int FRAC_W = 15,
  parameter int SLOT   = 30
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          start,
  input  logic                                          pixValid,
  input  logic [PIX_W-1:0]                              pixIn,
  output logic                                          done,
  output logic [sce_pkg::quotWidth(PIX_W, WIN_N, FRAC_W)-1:0] kOut
);
  localparam int S1_W      = sumWidth(PIX_W, WIN_N);
  localparam int S2_W      = sqWidth(PIX_W, WIN_N);
  localparam int RAD_W     = radWidth(PIX_W, WIN_N);
  localparam int ROOT_W    = RAD_W / 2;
  localparam int Q_W       = ROOT_W + FRAC_W;
  localparam int DIV_STEPS = Q_W / 2;

  sce_strobe_t strb;

  sce_control #(
    .WIN_N(WIN_N), .SLOT(SLOT), .ROOT_W(ROOT_W), .DIV_STEPS(DIV_STEPS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pixValid (pixValid),
    .strb     (strb)
  );

  sce_datapath #(
    .PIX_W(PIX_W), .WIN_N(WIN_N), .FRAC_W(FRAC_W), .S1_W(S1_W),
    .S2_W(S2_W), .RAD_W(RAD_W), .ROOT_W(ROOT_W)
  ) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strb  (strb),
    .pixIn (pixIn),
    .done  (done),
    .kOut  (kOut)
  );

endmodule

// File: rtl/sce_checker.sv
module sce_checker #(
  parameter int Q_W    = 28,
  parameter int FRAC_W = 15,
  parameter int WIN_N  = 25,
  parameter int SLOT   = 30,
  parameter int LAT    = 60
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic [Q_W-1:0] kOut,
  input logic           accStart
);
  function automatic int ceilRoot(int v);
    int r = 0;
    while (r * r < v) r++;
    return r;
  endfunction

  localparam logic [Q_W-1:0] K_BOUND = Q_W'(ceilRoot(WIN_N - 1)) << FRAC_W;

  logic [LAT-1:0] startHist;

  always_ff @(posedge clk) begin
    if (!rst_n) startHist <= '0;
    else        startHist <= {startHist[LAT-2:0], accStart};
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done == startHist[LAT-1]);

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accStart |-> (startHist[SLOT-2:0] == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(kOut));

  p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (kOut < K_BOUND));

endmodule

bind speckle_contrast_engine sce_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .kOut     (kOut),
  .accStart (strb.accFirst)
);

// File: tb/tb_speckle_contrast_engine.sv
module tb_speckle_contrast_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pixValid = 1'b0;
  logic [7:0]  pixIn = '0;
  logic        done;
  logic [27:0] kOut;

  always #5 clk = ~clk;

  speckle_contrast_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pixValid(pixValid),
    .pixIn(pixIn), .done(done), .kOut(kOut)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  longint edgeN = 0;
  longint expVal[longint];
  string  expTag[longint];
  string  frameTag = "R5";
  logic [27:0] lastK = '0;

  int px[30];
  bit vl[30];

  // model state
  int     mCnt = 0;
  int     mTaken = 0;
  longint ms1 = 0, ms2 = 0, mStart = 0;
  string  mTag = "";

  function automatic longint isqrt(longint v);
    longint r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  function automatic longint refK(longint s1, longint s2);
    if (s1 == 0) return 0;
    return (isqrt(25 * s2 - s1 * s1) << 15) / s1;
  endfunction

  task automatic takePix();
    if (pixValid && mTaken < 25) begin
      ms1 += longint'(pixIn);
      ms2 += longint'(pixIn) * longint'(pixIn);
      mTaken++;
    end
  endtask

  // behavioural reference: slot tracking and result schedule
  always @(posedge clk) begin
    if (rst_n) begin
      edgeN++;
      if (mCnt == 0) begin
        if (start) begin
          mCnt = 1; ms1 = 0; ms2 = 0; mTaken = 0; mStart = edgeN; mTag = frameTag;
          takePix();
        end
      end else begin
        takePix();
        mCnt++;
      end
      if (mCnt == 30) begin
        expVal[mStart + 59] = refK(ms1, ms2);
        expTag[mStart + 59] = mTag;
        mCnt = 0;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (expVal.exists(edgeN)) begin
        if (done !== 1'b1) begin
          errors++;
          $display("FAIL R4: done at edge %0d actual=%0d expected=1", edgeN, done);
        end
        checks++;
        if (kOut !== expVal[edgeN][27:0]) begin
          errors++;
          $display("FAIL %s: kOut at edge %0d actual=%0d expected=%0d",
                   expTag[edgeN], edgeN, kOut, expVal[edgeN]);
        end
        lastK = expVal[edgeN][27:0];
      end else begin
        if (done !== 1'b0) begin
          errors++;
          $display("FAIL R4 R2: unexpected done at edge %0d actual=%0d expected=0", edgeN, done);
        end
        if (kOut !== lastK) begin
          errors++;
          $display("FAIL R8: kOut moved at edge %0d actual=%0d expected=%0d", edgeN, kOut, lastK);
        end
      end
    end
  end

  task automatic runFrame(input int busyAt);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      start    = (k == 0) || (k == busyAt);
      pixValid = vl[k];
      pixIn    = 8'(px[k]);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    start = 0; pixValid = 0; pixIn = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic fillConst(input int v);
    for (int k = 0; k < 30; k++) begin px[k] = v; vl[k] = (k < 25); end
  endtask

  task automatic fillRandom();
    for (int k = 0; k < 30; k++) begin px[k] = int'($urandom_range(0, 255)); vl[k] = (k < 25); end
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not end actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || kOut !== 28'd0) begin
      errors++;
      $display("FAIL R1: reset outputs actual=%0d/%0d expected=0/0", done, kOut);
    end
    rst_n = 1'b1;

    frameTag = "R7"; fillConst(100); runFrame(-1); idle(70);      // uniform
    frameTag = "R6"; fillConst(0);   runFrame(-1); idle(70);      // zero mean
    frameTag = "R7"; fillConst(255); runFrame(-1); idle(70);      // uniform full scale

    frameTag = "R5";                                              // alternating 0/255
    for (int k = 0; k < 30; k++) begin px[k] = (k % 2) ? 255 : 0; vl[k] = (k < 25); end
    runFrame(-1); idle(70);

    frameTag = "R10";                                             // single bright sample
    fillConst(0); px[12] = 255; runFrame(-1); idle(70);

    frameTag = "R2"; fillRandom(); runFrame(10);                  // start mid-slot ignored
    frameTag = "R2"; fillRandom(); runFrame(29);                  // start on last slot cycle ignored
    frameTag = "R2"; fillRandom(); runFrame(-1); idle(70);        // next cycle start accepted

    frameTag = "R3";                                              // gaps and surplus samples
    for (int k = 0; k < 30; k++) begin px[k] = int'($urandom_range(0, 255)); vl[k] = (k % 7 != 3); end
    runFrame(-1); idle(70);
    frameTag = "R3";                                              // only 20 samples
    for (int k = 0; k < 30; k++) begin px[k] = int'($urandom_range(0, 255)); vl[k] = (k < 20); end
    runFrame(-1); idle(70);

    frameTag = "R9";                                              // back-to-back stream
    for (int f = 0; f < 20; f++) begin fillRandom(); runFrame(-1); end
    idle(80);

    summary();
  end

endmodule